// File: doc/BRIEF.md
# ROM Page-Mode Wait-State Generator

This block sets the number of wait states for bus cycles aimed at a page-mode ROM in a single chip-select area. Page-mode ROMs answer faster when a read lands in the same page as the read before it. The block therefore keeps the address of the last accepted cycle in its area. When a new cycle begins, it compares that address with the new one. A match on the page bits loads the short on-page wait count. Any other case loads the long off-page wait count. Each count is 0 to 7 cycles. The page size is 8 or 16 bytes and is chosen by a configuration input.

The bus controller pulses `bus_start` in the first cycle of every bus cycle. It raises `area_sel` when the address decodes to this ROM area. The block answers with `ready`, which is high for exactly one cycle: the cycle that ends the access. A new cycle may start in that same ready cycle, with no idle cycle between the two. Some things make the next cycle off-page whatever its address: a reset, an idle bus cycle, or a start into another area.

Top module: `rom_page_wait`

## Requirements
- R1: After reset `ready` is low and no access is in progress. The first access into the area after reset uses the off-page count.
- R2: For an access whose start is sampled in cycle C0 with a selected wait count N, `ready` is high in cycle C0+N+1 and low in cycles C0+1 to C0+N.
- R3: With `page16` = 0, an access is on-page when the stored address and the new address agree in every bit from bit 3 upward.
- R4: With `page16` = 1, an access is on-page when the two addresses agree in every bit from bit 4 upward. A difference in bit 3 alone still counts as on-page.
- R5: A `bus_start` for this area that arrives in the ready cycle of the previous access is accepted at once. It is compared with the previous access's address.
- R6: A cycle with no access in progress and no `bus_start` makes the next access off-page.
- R7: A `bus_start` with `area_sel` low gives no `ready`. It makes the next access into the area off-page, even if that access follows in the very next cycle.
- R8: A `bus_start` that arrives while an access is waiting (and is not in its ready cycle) is ignored. It does not add a `ready` pulse and does not replace the stored address.
- R9: Every wait count from 0 to 7 is honoured on both the off-page and the on-page path, including zero.
- R10: `ready` is never high outside the completing cycle of an accepted access. In particular it is never high for two cycles in a row unless a new access with count 0 was accepted in the first of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_start | input | 1 | Pulse marking the first cycle of a bus cycle |
| area_sel | input | 1 | The current cycle targets this ROM area |
| addr | input | AW (24) | Byte address of the current cycle |
| page16 | input | 1 | Page size: 0 = 8 bytes, 1 = 16 bytes |
| wait_off | input | 3 | Wait states for an off-page access |
| wait_on | input | 3 | Wait states for an on-page access |
| ready | output | 1 | Access completes in this cycle |

## Verification
The bench goes after the page boundaries. A bit-3 difference tells the two page sizes apart: a design that used the wrong compare width would give the short count across an 8-byte boundary, or the long count inside a 16-byte page. Back-to-back starts in the ready cycle are driven with wait counts of zero. A counter that did not reload there would stretch the second access or drop its `ready`. Idle cycles, starts into another area and stray starts during a wait are each followed by a same-page address. A design that kept a stale stored address, or let a stray start through, would show the wrong latency or an extra `ready` pulse.

// File: rtl/rpw_pkg.sv
package rpw_pkg;

  localparam int WCW    = 3;
  localparam int MAX_AW = 32;

  typedef logic [WCW-1:0] wait_t;

  // Page compare: 8-byte pages ignore bits [2:0], 16-byte pages ignore [3:0].
  function automatic logic page_match(input logic [MAX_AW-1:0] a,
                                      input logic [MAX_AW-1:0] b,
                                      input logic              wide);
    logic [MAX_AW-1:0] diff;
    diff = a ^ b;
    if (wide) return (diff >> 4) == '0;
    else      return (diff >> 3) == '0;
  endfunction

  function automatic wait_t wait_pick(input logic hit,
                                      input wait_t on_cnt,
                                      input wait_t off_cnt);
    return hit ? on_cnt : off_cnt;
  endfunction

endpackage

// File: rtl/rpw_page_track.sv
module rpw_page_track
  import rpw_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          page16,
  input  logic          take_area,
  input  logic          take_other,
  input  logic          idle_cycle,
  output logic          hit
);

  logic [AW-1:0] prev_addr;
  logic          prev_valid;

  assign hit = prev_valid && page_match(MAX_AW'(addr), MAX_AW'(prev_addr), page16);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_addr  <= '0;
      prev_valid <= 1'b0;
    end else if (take_area) begin
      prev_addr  <= addr;
      prev_valid <= 1'b1;
    end else if (take_other || idle_cycle) begin
      prev_valid <= 1'b0;
    end
  end

  // R6: an idle cycle leaves no page history behind
  assert_idle_forgets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    idle_cycle |=> !hit);

  // R7: a start into another area leaves no page history behind
  assert_other_forgets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take_other |=> !hit);

  // R8: the stored address changes only on an accepted start in this area
  assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !take_area |=> $stable(prev_addr));

endmodule

// File: rtl/rpw_wait_count.sv
module rpw_wait_count
  import rpw_pkg::*;
#(
  parameter int CW = WCW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          active,
  output logic          ready
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (load) begin
      active <= 1'b1;
      cnt    <= load_val;
    end else if (active) begin
      if (cnt == '0) active <= 1'b0;
      else           cnt    <= cnt - CW'(1);
    end
  end

  assign ready = active && (cnt == '0);

  // R2: zero wait completes in the very next cycle
  assert_zero_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val == '0) |=> ready);

  // R2: a non-zero wait never completes in the next cycle
  assert_no_early_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val != '0) |=> !ready);

  // R10: one ready pulse per access unless reloaded
  assert_single_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !load) |=> !ready);

endmodule

// File: rtl/rom_page_wait.sv
module rom_page_wait
  import rpw_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_start,
  input  logic          area_sel,
  input  logic [AW-1:0] addr,
  input  logic          page16,
  input  logic [WCW-1:0] wait_off,
  input  logic [WCW-1:0] wait_on,
  output logic          ready
);

  logic  active;
  logic  can_start;
  logic  take_area;
  logic  take_other;
  logic  idle_cycle;
  logic  page_hit;
  wait_t wait_sel;

  // Named events
  assign can_start  = !active || ready;
  assign take_area  = bus_start && can_start && area_sel;
  assign take_other = bus_start && can_start && !area_sel;
  assign idle_cycle = !active && !bus_start;
  assign wait_sel   = wait_pick(page_hit, wait_on, wait_off);

  rpw_page_track #(.AW(AW)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .page16     (page16),
    .take_area  (take_area),
    .take_other (take_other),
    .idle_cycle (idle_cycle),
    .hit        (page_hit)
  );

  rpw_wait_count #(.CW(WCW)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (take_area),
    .load_val (wait_sel),
    .active   (active),
    .ready    (ready)
  );

  // R8: a start during a wait does not restart the count
  assert_ignore_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_start && active && !ready) |=> active);

  // R7: a start into another area from idle gives no ready next cycle
  assert_other_no_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take_other && !active) |=> !ready);

  // R1: the first clock after reset has no completion
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> !ready);

endmodule

// File: tb/rom_page_wait_test.sv
module rom_page_wait_test;

  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_start = 1'b0;
  logic          area_sel = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          page16 = 1'b0;
  logic [2:0]    wait_off = 3'd5;
  logic [2:0]    wait_on = 3'd2;
  logic          ready;

  always #2 clk = ~clk;

  rom_page_wait #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .area_sel(area_sel),
    .addr(addr), .page16(page16), .wait_off(wait_off), .wait_on(wait_on),
    .ready(ready)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  int    exp_q[$];
  string tag_q[$];
  bit    mbusy = 0;
  int    lat = 0;
  bit    finished = 0;

  // Bench-side page model
  bit            mvalid = 0;
  logic [AW-1:0] mprev = '0;

  function automatic int model_take(input logic [AW-1:0] a);
    int sh;
    bit h;
    sh = page16 ? 4 : 3;
    h = mvalid && ((a >> sh) == (mprev >> sh));
    mprev = a;
    mvalid = 1;
    return h ? int'(wait_on) : int'(wait_off);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Monitor: measure latency and compare with the scoreboard
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (ready) begin
        if (!mbusy || exp_q.size() == 0) begin
          check(0, "R10 spurious ready", 1, 0);
        end else begin
          int    e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(lat == e, t, lat, e);
          mbusy = 0;
        end
      end
      if (mbusy) lat++;
      if (bus_start && area_sel && !mbusy) begin
        mbusy = 1;
        lat = 0;
      end
    end
  end

  task automatic push(input int e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic wait_done();
    forever begin
      @(negedge clk); #1;
      if (!mbusy) break;
    end
  endtask

  task automatic single(input logic [AW-1:0] a, input string t);
    @(posedge clk); #1;
    push(model_take(a), t);
    addr = a; area_sel = 1; bus_start = 1;
    @(posedge clk); #1;
    bus_start = 0;
    wait_done();
  endtask

  task automatic idle_gap(input int n);
    repeat (n) begin @(posedge clk); #1; end
    mvalid = 0;
  endtask

  // Second start lands in the ready cycle of the first (R5)
  task automatic pair(input logic [AW-1:0] a1, input logic [AW-1:0] a2, input string t);
    int e1;
    @(posedge clk); #1;
    e1 = model_take(a1);
    push(e1, t);
    addr = a1; area_sel = 1; bus_start = 1;
    for (int k = 1; k <= e1 + 1; k++) begin
      @(posedge clk); #1;
      if (k == e1 + 1) begin
        push(model_take(a2), t);
        addr = a2; bus_start = 1;
      end else begin
        bus_start = 0;
      end
    end
    @(posedge clk); #1;
    bus_start = 0;
    wait_done();
  endtask

  // Start into another area, then at once into this one (R7)
  task automatic other_then(input logic [AW-1:0] ao, input logic [AW-1:0] a, input string t);
    @(posedge clk); #1;
    addr = ao; area_sel = 0; bus_start = 1;
    mvalid = 0;
    @(posedge clk); #1;
    push(model_take(a), t);
    addr = a; area_sel = 1; bus_start = 1;
    @(negedge clk);
    check(ready == 1'b0, "R7 no ready from other area", int'(ready), 0);
    @(posedge clk); #1;
    bus_start = 0;
    wait_done();
  endtask

  // Stray start two cycles into a long wait (R8)
  task automatic stray(input logic [AW-1:0] a1, input logic [AW-1:0] bad, input string t);
    @(posedge clk); #1;
    push(model_take(a1), t);
    addr = a1; area_sel = 1; bus_start = 1;
    @(posedge clk); #1;
    bus_start = 0;
    @(posedge clk); #1;
    addr = bad; bus_start = 1;
    @(posedge clk); #1;
    bus_start = 0;
    wait_done();
  endtask

  task automatic finish_run();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(ready == 1'b0, "R1 ready low in reset", int'(ready), 0);
    @(posedge clk); #1;
    rst_n = 1;
    @(negedge clk);
    check(ready == 1'b0, "R1 ready low after reset", int'(ready), 0);

    // 8-byte pages, off=5 on=2
    single(24'h000100, "R1 first access off-page");
    single(24'h000104, "R3 same 8-byte page");
    single(24'h000108, "R3 bit3 differs 8-byte");
    single(24'h00010F, "R3 same page top byte");
    single(24'h800108, "R3 high bit differs");

    // 16-byte pages
    page16 = 1;
    single(24'h000100, "R4 off-page");
    single(24'h00010C, "R4 bit3 differs same 16-byte page");
    single(24'h000110, "R4 next 16-byte page");
    single(24'h00011F, "R4 same page");

    idle_gap(1);
    single(24'h000114, "R6 after idle off-page");

    pair(24'h000118, 24'h00011C, "R5 back-to-back");
    other_then(24'h00011A, 24'h00011B, "R7 after other area off-page");

    stray(24'h000200, 24'h000300, "R8 wait unchanged by stray start");
    single(24'h000204, "R8 stored address kept");

    // Extreme counts
    wait_off = 3'd7; wait_on = 3'd0;
    single(24'h000208, "R9 on-page zero");
    single(24'h000400, "R9 off-page seven");
    pair(24'h000404, 24'h000408, "R5 R9 back-to-back zero waits");
    wait_off = 3'd0; wait_on = 3'd7;
    single(24'h000500, "R9 off-page zero");
    single(24'h000501, "R9 on-page seven");

    // Reset clears page history
    @(posedge clk); #1;
    rst_n = 0;
    mvalid = 0;
    @(posedge clk); #1;
    @(negedge clk);
    check(ready == 1'b0, "R1 ready low in second reset", int'(ready), 0);
    @(posedge clk); #1;
    rst_n = 1;
    single(24'h000501, "R1 off-page after reset");

    repeat (4) @(posedge clk);
    check(exp_q.size() == 0, "R10 all accesses completed", exp_q.size(), 0);
    finish_run();
  end

endmodule